// File: doc/BRIEF.md
# OTG Status and VBUS Change Tracker

This block keeps a 16-bit OTG status word that mirrors the VBUS and session indications reported by a USB controller core. Each indication arrives as a level qualified by a single-cycle strobe. A VBUS strobe writes the VBUS-valid bit. A session strobe writes a pair of bits, session-valid and session-end, which are always complements of each other once written.

When a VBUS strobe carries a level different from the stored VBUS-valid bit, the block emits a one-cycle change pulse, driven from a register. A strobe that repeats the stored level emits nothing. Session updates never emit a pulse. The pulse is meant to feed the VBUS-sense-change position (bit 15) of the chip-level interrupt source register.

The strobes are plain control pins with no back-pressure. Every strobe is taken in the cycle it is high, and a VBUS strobe and a session strobe in the same cycle are both applied. The block does not model ID detection, line state, host disconnect, VBUS sense or power/clock good, so those bits always read as zero.

Top module: `otg_status_tracker`

## Requirements
- R1: After reset, the status word is 16'h0000 and the change pulse is low.
- R2: Bit 5 (VBUS-valid) takes the level of a VBUS strobe on the clock edge that samples the strobe. Without a VBUS strobe, bit 5 keeps its value.
- R3: When a VBUS strobe carries a level that differs from the stored bit 5, the change pulse is high for exactly the one cycle after the sampling edge.
- R4: A VBUS strobe carrying the same level as the stored bit 5 leaves the change pulse low. Without a VBUS strobe, the change pulse is low.
- R5: A session strobe with level 1 sets bit 6 (session valid) and clears bit 7 (session end) on the sampling edge.
- R6: A session strobe with level 0 clears bit 6 and sets bit 7 on the sampling edge. Without a session strobe, bits 7:6 keep their values.
- R7: A session strobe never raises the change pulse.
- R8: Bits 15:9, 8 (power/clock good), 4 (VBUS sense), 3 (ID status), 2 (host disconnect) and 1:0 (line state) always read 0.
- R9: A VBUS strobe and a session strobe in the same cycle are both applied on that edge, and the pulse follows R3/R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vbus_stb | input | 1 | VBUS indication strobe |
| vbus_lvl | input | 1 | VBUS-valid level, sampled with vbus_stb |
| sess_stb | input | 1 | Session indication strobe |
| sess_lvl | input | 1 | Session-valid level, sampled with sess_stb |
| stat_word | output | 16 | OTG status word |
| vbus_chg_pulse | output | 1 | One-cycle VBUS-sense-change request |

## Verification
All state in this block is visible at the ports one cycle after it is written. A wrong stored VBUS bit therefore shows up at once on bit 5. It also shows up at the next VBUS strobe as a missing or spurious change pulse. A session pair stuck equal, or a reserved bit leaking, appears on stat_word on the very next cycle. The bench compares both outputs against a behavioural model on every clock, under random strobes that include repeats, toggles and coincident updates.

// File: rtl/otg_stat_pkg.sv
package otg_stat_pkg;
  parameter int STAT_W       = 16;
  parameter int BIT_VBUS_OK  = 5;
  parameter int BIT_SESS_OK  = 6;
  parameter int BIT_SESS_END = 7;

  typedef logic [STAT_W-1:0] stat_word_t;

  typedef struct packed {
    logic sess_end;
    logic sess_ok;
  } sess_pair_t;
endpackage

// File: rtl/otg_vbus_track.sv
module otg_vbus_track (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic lvl,
  output logic vbus_ok,
  output logic chg_pulse
);
  logic differs;

  assign differs = stb && (lvl != vbus_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbus_ok   <= 1'b0;
      chg_pulse <= 1'b0;
    end else begin
      chg_pulse <= differs;
      if (stb) vbus_ok <= lvl;
    end
  end
endmodule

// File: rtl/otg_sess_track.sv
module otg_sess_track
  import otg_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb,
  input  logic       lvl,
  output sess_pair_t pair
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair <= '0;
    end else if (stb) begin
      pair.sess_ok  <= lvl;
      pair.sess_end <= ~lvl;
    end
  end
endmodule

// File: rtl/otg_status_tracker.sv
module otg_status_tracker
  import otg_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vbus_stb,
  input  logic              vbus_lvl,
  input  logic              sess_stb,
  input  logic              sess_lvl,
  output logic [STAT_W-1:0] stat_word,
  output logic              vbus_chg_pulse
);
  logic       vbus_ok;
  sess_pair_t sess;

  otg_vbus_track u_vbus (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (vbus_stb),
    .lvl       (vbus_lvl),
    .vbus_ok   (vbus_ok),
    .chg_pulse (vbus_chg_pulse)
  );

  otg_sess_track u_sess (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (sess_stb),
    .lvl   (sess_lvl),
    .pair  (sess)
  );

  always_comb begin
    stat_word               = '0;
    stat_word[BIT_VBUS_OK]  = vbus_ok;
    stat_word[BIT_SESS_OK]  = sess.sess_ok;
    stat_word[BIT_SESS_END] = sess.sess_end;
  end
endmodule

// File: rtl/otg_status_tracker_chk.sv
module otg_status_tracker_chk
  import otg_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              vbus_stb,
  input logic              vbus_lvl,
  input logic              sess_stb,
  input logic              sess_lvl,
  input logic [STAT_W-1:0] stat_word,
  input logic              vbus_chg_pulse
);
  localparam logic [STAT_W-1:0] LIVE_MASK =
    (STAT_W'(1) << BIT_VBUS_OK) | (STAT_W'(1) << BIT_SESS_OK) | (STAT_W'(1) << BIT_SESS_END);

  p_vbus_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_stb |=> stat_word[BIT_VBUS_OK] == $past(vbus_lvl));

  p_vbus_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vbus_stb |=> $stable(stat_word[BIT_VBUS_OK]));

  p_pulse_on_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus_stb && vbus_lvl != stat_word[BIT_VBUS_OK]) |=> vbus_chg_pulse);

  p_no_pulse_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!vbus_stb || vbus_lvl == stat_word[BIT_VBUS_OK]) |=> !vbus_chg_pulse);

  p_sess_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_stb && sess_lvl) |=> (stat_word[BIT_SESS_OK] && !stat_word[BIT_SESS_END]));

  p_sess_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_stb && !sess_lvl) |=> (!stat_word[BIT_SESS_OK] && stat_word[BIT_SESS_END]));

  p_sess_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_stb && !vbus_stb) |=> !vbus_chg_pulse);

  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word & ~LIVE_MASK) == '0);
endmodule

bind otg_status_tracker otg_status_tracker_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .vbus_stb       (vbus_stb),
  .vbus_lvl       (vbus_lvl),
  .sess_stb       (sess_stb),
  .sess_lvl       (sess_lvl),
  .stat_word      (stat_word),
  .vbus_chg_pulse (vbus_chg_pulse)
);

// File: tb/otg_status_tracker_tb.sv
`timescale 1ns/1ps
module otg_status_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vbus_stb = 1'b0, vbus_lvl = 1'b0, sess_stb = 1'b0, sess_lvl = 1'b0;
  logic [15:0] stat_word;
  logic        vbus_chg_pulse;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  int m_vbus = 0, m_sv = 0, m_se = 0, m_pulse = 0;

  always #2.5 clk = ~clk;

  otg_status_tracker u_dut (
    .clk(clk), .rst_n(rst_n),
    .vbus_stb(vbus_stb), .vbus_lvl(vbus_lvl),
    .sess_stb(sess_stb), .sess_lvl(sess_lvl),
    .stat_word(stat_word), .vbus_chg_pulse(vbus_chg_pulse)
  );

  function automatic logic [15:0] exp_word();
    return 16'((m_se << 7) | (m_sv << 6) | (m_vbus << 5));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [15:0] e;
    e = exp_word();
    chk(stat_word[5] == e[5], "R2 vbus bit", int'(stat_word), int'(e));
    chk(stat_word[7:6] == e[7:6], "R5/R6 session bits", int'(stat_word), int'(e));
    chk((stat_word & 16'hFF1F) == 16'h0, "R8 unused bits", int'(stat_word), 0);
    chk(vbus_chg_pulse == m_pulse[0], "R3/R4 change pulse", int'(vbus_chg_pulse), m_pulse);
  endtask

  // Drive one cycle of strobes at a falling edge, advance the model, compare at the next falling edge.
  task automatic step(input bit vs, input bit vl, input bit ss, input bit sl);
    vbus_stb = vs; vbus_lvl = vl; sess_stb = ss; sess_lvl = sl;
    m_pulse = (vs && (int'(vl) != m_vbus)) ? 1 : 0;
    if (vs) m_vbus = int'(vl);
    if (ss) begin m_sv = int'(sl); m_se = sl ? 0 : 1; end
    @(negedge clk);
    vbus_stb = 0; sess_stb = 0;
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(stat_word == 16'h0, "R1 reset word", int'(stat_word), 0);
    chk(vbus_chg_pulse == 1'b0, "R1 reset pulse", int'(vbus_chg_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    step(1, 1, 0, 0);  // R3 toggle 0->1
    chk(vbus_chg_pulse == 1'b1 && stat_word[5], "R3 rise pulse", int'(vbus_chg_pulse), 1);
    step(0, 0, 0, 0);  // R3 pulse lasts one cycle
    chk(vbus_chg_pulse == 1'b0, "R3 single cycle", int'(vbus_chg_pulse), 0);
    step(1, 1, 0, 0);  // R4 repeat
    chk(vbus_chg_pulse == 1'b0, "R4 repeat level", int'(vbus_chg_pulse), 0);
    step(0, 0, 0, 0);
    chk(stat_word[5] == 1'b1, "R2 hold without strobe", int'(stat_word[5]), 1);
    step(1, 0, 0, 0);  // R3 toggle 1->0
    chk(vbus_chg_pulse == 1'b1 && !stat_word[5], "R3 fall pulse", int'(vbus_chg_pulse), 1);
    step(0, 0, 1, 1);  // R5
    chk(stat_word == 16'h0040, "R5 session valid", int'(stat_word), 16'h0040);
    chk(vbus_chg_pulse == 1'b0, "R7 session no pulse", int'(vbus_chg_pulse), 0);
    step(0, 0, 1, 0);  // R6
    chk(stat_word == 16'h0080, "R6 session end", int'(stat_word), 16'h0080);
    chk(vbus_chg_pulse == 1'b0, "R7 session no pulse", int'(vbus_chg_pulse), 0);
    step(1, 1, 1, 1);  // R9 coincident
    chk(stat_word == 16'h0060 && vbus_chg_pulse, "R9 coincident update", int'(stat_word), 16'h0060);
    step(1, 1, 1, 0);  // R9 coincident, repeated vbus
    chk(stat_word == 16'h00A0 && !vbus_chg_pulse, "R9 coincident repeat", int'(stat_word), 16'h00A0);

    for (int i = 0; i < 4000; i++) begin
      step(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end

    // Mid-run reset returns to R1 state
    rst_n = 1'b0;
    m_vbus = 0; m_sv = 0; m_se = 0; m_pulse = 0;
    @(negedge clk);
    chk(stat_word == 16'h0 && !vbus_chg_pulse, "R1 reset again", int'(stat_word), 0);
    finish_run();
  end
endmodule